// File: doc/BRIEF.md
# Sampled-Clock SPI Slave

This block is the receive and transmit engine of a serial peripheral port that always acts as the slave. It runs entirely on the local system clock. The serial clock, the active-low select and the data input from the bus are treated as ordinary asynchronous inputs. Each one passes through a two-stage synchroniser. Transitions of the synchronised serial clock are then classified as sampling or shifting edges from the configured idle level (`cpol_i`) and phase (`cpha_i`). Data moves most significant bit first in both directions.

Software preloads the next outgoing character straight into the shift register while no character is in flight. If it does not, the register's current content goes out instead, which is the character just received. Every complete character is copied into a receive holding register, so software has one full character time to read it. Sticky completion, write-collision and overrun flags are combined into one interrupt line.

Top module: `spi_sampled_slave`

## Requirements
- R1: While `master_en_i` is 1, the block ignores the bus. `miso_oe_o` stays 0, `busy_o` stays 0, and serial clock edges neither complete a character nor change `rd_data_o`.
- R2: With `ssel_n_i` low, one character is 8 sampling edges. The first bit sampled on `mosi_i` lands in the most significant bit of `rd_data_o`. For every `cpol_i`/`cpha_i` combination this holds: `cpol_i` is the idle level of the serial clock, a leading edge leaves that level, and `cpha_i`=0 samples on leading edges while `cpha_i`=1 samples on trailing edges.
- R3: On `miso_o` the loaded character goes out most significant bit first. With `cpha_i`=0, the first bit is valid once the select has been seen and before the first edge. With `cpha_i`=1, it appears after the first leading edge. Later bits change on the edges that do not sample.
- R4: Reception is correct when the serial clock period is only 4 system clocks (2 clocks high, 2 clocks low).
- R5: `done_o` rises at the fourth rising system clock edge after the final sampling serial clock transition is applied. In that same cycle `rd_data_o` holds the new character and `busy_o` is 0.
- R6: If no write happens between two characters, the next transmitted character equals the last character received.
- R7: A `wr_en_i` pulse while `busy_o` is 1 sets the sticky `wcol_o`. The written value is dropped, and the character in flight is sent and received unchanged.
- R8: When a character completes while the previous one is still unread (no `rd_en_i` since its arrival), `ovr_o` is set and `rd_data_o` takes the newer character. Characters that are read in time never set `ovr_o`.
- R9: Raising `ssel_n_i` part-way through a character discards the partial bits. No completion is reported, `busy_o` drops, and the next full character is received correctly.
- R10: `done_o`, `wcol_o` and `ovr_o` stay set until their own clear input (`clr_done_i`, `clr_wcol_i`, `clr_ovr_i`) is pulsed. `irq_o` is `irq_en_i` ANDed with the OR of the three flags.
- R11: `busy_o` is 0 after select and before the first serial clock edge. It is 1 from the first edge of a character until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en_i | input | 1 | 1 disables the slave engine |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| irq_en_i | input | 1 | Interrupt enable |
| sck_i | input | 1 | Serial clock from the bus master (asynchronous) |
| ssel_n_i | input | 1 | Slave select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out pin |
| wr_en_i | input | 1 | Load `wr_data_i` into the shift register |
| wr_data_i | input | 8 | Character to transmit |
| rd_en_i | input | 1 | Marks the receive holding register as read |
| rd_data_o | output | 8 | Receive holding register |
| clr_done_i | input | 1 | Clears the completion flag |
| clr_wcol_i | input | 1 | Clears the write-collision flag |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| busy_o | output | 1 | Character in flight |
| done_o | output | 1 | Sticky completion flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The latency that matters is three clocks from a serial clock transition to the shift register: two synchroniser stages, then the registered edge. Completion comes one clock later. The bench therefore compares the time stamp at which `done_o` is first seen against the time the final sampling edge was applied, and expects exactly four clock periods; busy and the receive data are checked in that same sample. Transmit bits are read just before each master sampling edge, with half periods of at least four clocks, so `miso_o` has settled. Flags, overrun and discard cases are checked a few clocks after the select is released, when no serial activity is pending.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    // Data phase selection: which serial clock edge samples the input line
    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } spi_phase_e;

    // Per-cycle serial events produced by the synchroniser stage
    typedef struct packed {
        logic sel;      // slave selected and engine enabled
        logic sample;   // sampling edge seen this cycle
        logic shift;    // output-change edge seen this cycle
        logic mosi;     // synchronised serial input level
    } spi_evt_t;

endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync
    import spi_slave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_i,
    input  logic     ssel_n_i,
    input  logic     mosi_i,
    input  logic     cpol_i,
    input  logic     cpha_i,
    input  logic     master_en_i,
    output spi_evt_t evt_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ssn;
        logic [STAGES-1:0] mosi;
        logic              sck_prev;
    } sync_st_t;

    localparam sync_st_t RST_VAL = '{
        sck:      '0,
        ssn:      '1,
        mosi:     '0,
        sck_prev: 1'b0
    };

    sync_st_t st_q, st_d;
    logic     sck_s, edge_s, lead_s, trail_s, sel_s;

    always_comb begin
        st_d          = st_q;
        st_d.sck      = {st_q.sck[STAGES-2:0], sck_i};
        st_d.ssn      = {st_q.ssn[STAGES-2:0], ssel_n_i};
        st_d.mosi     = {st_q.mosi[STAGES-2:0], mosi_i};
        sck_s         = st_q.sck[STAGES-1];
        st_d.sck_prev = sck_s;

        sel_s   = !st_q.ssn[STAGES-1] && !master_en_i;
        edge_s  = sck_s ^ st_q.sck_prev;
        lead_s  = edge_s && (sck_s != cpol_i);
        trail_s = edge_s && (sck_s == cpol_i);

        evt_o.sel    = sel_s;
        evt_o.mosi   = st_q.mosi[STAGES-1];
        if (spi_phase_e'(cpha_i) == PH_TRAIL) begin
            evt_o.sample = sel_s && trail_s;
            evt_o.shift  = sel_s && lead_s;
        end else begin
            evt_o.sample = sel_s && lead_s;
            evt_o.shift  = sel_s && trail_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    AST_EDGE_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_o.sample && evt_o.shift)); // R2

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter
    import spi_slave_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  spi_evt_t     evt_i,
    input  logic         cpha_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic         miso_o,
    output logic         busy_o,
    output logic         collide_o,
    output logic         last_o,
    output logic [W-1:0] rx_word_o
);

    localparam int           CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          last;
        logic          miso;
    } shf_st_t;

    shf_st_t st_q, st_d;
    logic    collide_d;

    always_comb begin
        st_d      = st_q;
        st_d.last = 1'b0;
        collide_d = 1'b0;

        if (!evt_i.sel) begin
            st_d.cnt  = '0;
            st_d.busy = 1'b0;
            if (wr_en_i) st_d.sr = wr_data_i;
            st_d.miso = st_d.sr[W-1];
        end else begin
            if (st_q.last) st_d.busy = 1'b0;

            if (wr_en_i) begin
                if (st_q.busy) collide_d = 1'b1;
                else           st_d.sr   = wr_data_i;
            end

            if (evt_i.shift) begin
                st_d.miso = st_q.sr[W-1];
                if (spi_phase_e'(cpha_i) == PH_TRAIL) st_d.busy = 1'b1;
            end

            if (evt_i.sample) begin
                st_d.busy = 1'b1;
                st_d.sr   = {st_q.sr[W-2:0], evt_i.mosi};
                if (st_q.cnt == LAST) begin
                    st_d.cnt  = '0;
                    st_d.last = 1'b1;
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end

            // leading-edge phase: first bit follows the register until the character starts
            if (spi_phase_e'(cpha_i) == PH_LEAD && !st_q.busy && !evt_i.sample)
                st_d.miso = st_d.sr[W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o    = st_q.miso;
    assign busy_o    = st_q.busy;
    assign collide_o = collide_d;
    assign last_o    = st_q.last;
    assign rx_word_o = st_q.sr;

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i.sel |=> (!st_q.busy && st_q.cnt == '0)); // R9
    AST_LAST_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.last |=> !st_q.busy); // R5

endmodule

// File: rtl/spi_slave_flags.sv
module spi_slave_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         last_i,
    input  logic [W-1:0] rx_word_i,
    input  logic         collide_i,
    input  logic         rd_en_i,
    input  logic         clr_done_i,
    input  logic         clr_wcol_i,
    input  logic         clr_ovr_i,
    input  logic         irq_en_i,
    output logic [W-1:0] rd_data_o,
    output logic         done_o,
    output logic         wcol_o,
    output logic         ovr_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] rxbuf;
        logic         full;
        logic         done;
        logic         wcol;
        logic         ovr;
    } flg_st_t;

    flg_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_en_i)    st_d.full = 1'b0;
        if (clr_done_i) st_d.done = 1'b0;
        if (clr_wcol_i) st_d.wcol = 1'b0;
        if (clr_ovr_i)  st_d.ovr  = 1'b0;

        if (last_i) begin
            st_d.rxbuf = rx_word_i;
            if (st_q.full && !rd_en_i) st_d.ovr = 1'b1;
            st_d.full = 1'b1;
            st_d.done = 1'b1;
        end
        if (collide_i) st_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rxbuf;
    assign done_o    = st_q.done;
    assign wcol_o    = st_q.wcol;
    assign ovr_o     = st_q.ovr;
    assign irq_o     = irq_en_i && (st_q.done || st_q.wcol || st_q.ovr);

    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wcol && !clr_wcol_i) |=> st_q.wcol); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !clr_ovr_i) |=> st_q.ovr); // R10
    AST_OVR_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.full)); // R8

endmodule

// File: rtl/spi_sampled_slave.sv
module spi_sampled_slave
    import spi_slave_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              irq_en_i,
    input  logic              sck_i,
    input  logic              ssel_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              clr_done_i,
    input  logic              clr_wcol_i,
    input  logic              clr_ovr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wcol_o,
    output logic              ovr_o,
    output logic              irq_o
);

    spi_evt_t          evt;
    logic              collide, last;
    logic [DATA_W-1:0] rx_word;

    spi_slave_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (sck_i),
        .ssel_n_i    (ssel_n_i),
        .mosi_i      (mosi_i),
        .cpol_i      (cpol_i),
        .cpha_i      (cpha_i),
        .master_en_i (master_en_i),
        .evt_o       (evt)
    );

    spi_slave_shifter #(.W(DATA_W)) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .cpha_i    (cpha_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .miso_o    (miso_o),
        .busy_o    (busy_o),
        .collide_o (collide),
        .last_o    (last),
        .rx_word_o (rx_word)
    );

    spi_slave_flags #(.W(DATA_W)) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_i     (last),
        .rx_word_i  (rx_word),
        .collide_i  (collide),
        .rd_en_i    (rd_en_i),
        .clr_done_i (clr_done_i),
        .clr_wcol_i (clr_wcol_i),
        .clr_ovr_i  (clr_ovr_i),
        .irq_en_i   (irq_en_i),
        .rd_data_o  (rd_data_o),
        .done_o     (done_o),
        .wcol_o     (wcol_o),
        .ovr_o      (ovr_o),
        .irq_o      (irq_o)
    );

    assign miso_oe_o = evt.sel;

    AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o); // R5
    AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        master_en_i |=> !busy_o); // R1
    AST_WCOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_o) |-> $past(busy_o && wr_en_i)); // R7

endmodule

// File: tb/test_spi_sampled_slave.sv
`timescale 1ns/1ps
module test_spi_sampled_slave;

    localparam real PERIOD = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0, cpol = 1'b0, cpha = 1'b0, irq_en = 1'b0;
    logic       sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0;
    logic       miso_o, miso_oe_o;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data_o;
    logic       clr_done = 1'b0, clr_wcol = 1'b0, clr_ovr = 1'b0;
    logic       busy_o, done_o, wcol_o, ovr_o, irq_o;

    int   checks = 0, errors = 0;
    bit   finished = 1'b0;
    int   wr_at = -1;
    logic [7:0] wr_val = 8'h00;
    logic busy_mid = 1'b0;
    time  final_t = 0, done_t = 0;
    logic done_busy = 1'b0, done_prev = 1'b0;
    logic [7:0] done_data = 8'h00;

    always #(PERIOD/2.0) clk = ~clk;

    spi_sampled_slave i_spi_sampled_slave (
        .clk(clk), .rst_n(rst_n), .master_en_i(master_en), .cpol_i(cpol), .cpha_i(cpha),
        .irq_en_i(irq_en), .sck_i(sck), .ssel_n_i(ssel_n), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data_o), .clr_done_i(clr_done),
        .clr_wcol_i(clr_wcol), .clr_ovr_i(clr_ovr), .busy_o(busy_o), .done_o(done_o),
        .wcol_o(wcol_o), .ovr_o(ovr_o), .irq_o(irq_o)
    );

    // completion monitor: time stamp of each rising done
    always @(negedge clk) begin
        if (done_o && !done_prev) begin
            done_t    = $time;
            done_busy = busy_o;
            done_data = rd_data_o;
        end
        done_prev = done_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        wait_clk(1);
        wr_en = 1'b0;
    endtask

    task automatic ack_all();
        rd_en = 1'b1; clr_done = 1'b1; clr_wcol = 1'b1; clr_ovr = 1'b1;
        wait_clk(1);
        rd_en = 1'b0; clr_done = 1'b0; clr_wcol = 1'b0; clr_ovr = 1'b0;
        wait_clk(1);
    endtask

    task automatic do_select();
        sck = cpol;
        wait_clk(4);
        done_t = 0;
        ssel_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic do_deselect();
        ssel_n = 1'b1;
        wait_clk(6);
    endtask

    // bus master model: nbits of mo out, returns bits seen on miso
    task automatic xfer(input logic [7:0] mo, input int nbits, input int half, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                wait_clk(half);
                mi[7-i] = miso_o;
                sck = ~cpol;
                if (i == nbits-1) final_t = $time;
                wait_clk(half);
                if (i == 1) busy_mid = busy_o;
                if (i == wr_at) pulse_wr(wr_val);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[7-i];
                wait_clk(half);
                mi[7-i] = miso_o;
                if (i == 1) busy_mid = busy_o;
                if (i == wr_at) pulse_wr(wr_val);
                sck = cpol;
                if (i == nbits-1) final_t = $time;
                wait_clk(half);
            end
        end
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] mi, data, tx, last_rx;
        int unsigned seed_v;
        int half;
        bit do_wr;
        seed_v = $urandom(32'h5EED_0A11);

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk(!done_o && !wcol_o && !ovr_o && !busy_o && !irq_o && rd_data_o == 8'h00,
            "reset", {done_o, wcol_o, ovr_o, busy_o, irq_o}, 0);

        // random transfers, all modes (R2 R3 R5 R6 R11)
        last_rx = 8'h00;
        for (int n = 0; n < 24; n++) begin
            cpol  = 1'($urandom % 2);
            cpha  = 1'($urandom % 2);
            half  = 4 + int'($urandom % 3);
            data  = 8'($urandom);
            do_wr = ($urandom % 4) != 0;
            tx    = last_rx;
            if (do_wr) begin
                tx = 8'($urandom);
                pulse_wr(tx);
            end
            do_select();
            chk(busy_o == 1'b0, "R11 idle before first edge", busy_o, 0);
            xfer(data, 8, half, mi);
            chk(busy_mid == 1'b1, "R11 busy during character", busy_mid, 1);
            chk(done_t - final_t == 4 * 5, "R5 done latency", 32'(done_t - final_t), 20);
            chk(done_busy == 1'b0 && done_data == data, "R5 data and idle with done",
                {done_busy, done_data}, {1'b0, data});
            do_deselect();
            chk(rd_data_o == data, "R2 received character", rd_data_o, data);
            chk(mi == tx, do_wr ? "R3 transmitted character" : "R6 resend last received", mi, tx);
            last_rx = data;
            ack_all();
        end
        chk(ovr_o == 1'b0, "R8 no overrun when read in time", ovr_o, 0);

        // R4: serial clock at a quarter of the system clock
        cpol = 1'b0; cpha = 1'b0;
        do_select(); xfer(8'hA5, 8, 2, mi); do_deselect();
        chk(rd_data_o == 8'hA5, "R4 quarter rate mode 0", rd_data_o, 8'hA5);
        ack_all();
        cpol = 1'b1; cpha = 1'b1;
        do_select(); xfer(8'h3C, 8, 2, mi); do_deselect();
        chk(rd_data_o == 8'h3C, "R4 quarter rate mode 3", rd_data_o, 8'h3C);
        ack_all();

        // R7 write collision
        cpol = 1'b0; cpha = 1'b0; irq_en = 1'b1;
        pulse_wr(8'h96);
        wr_at = 3; wr_val = 8'h55;
        do_select(); xfer(8'h0F, 8, 4, mi); do_deselect();
        wr_at = -1;
        chk(wcol_o == 1'b1, "R7 collision flag", wcol_o, 1);
        chk(mi == 8'h96, "R7 transmit unchanged", mi, 8'h96);
        chk(rd_data_o == 8'h0F, "R7 receive unchanged", rd_data_o, 8'h0F);
        chk(irq_o == 1'b1, "R10 irq from flags", irq_o, 1);
        rd_en = 1'b1; clr_done = 1'b1; wait_clk(1); rd_en = 1'b0; clr_done = 1'b0;
        wait_clk(5);
        chk(wcol_o == 1'b1, "R10 collision flag sticky", wcol_o, 1);
        clr_wcol = 1'b1; wait_clk(1); clr_wcol = 1'b0; wait_clk(1);
        chk(wcol_o == 1'b0 && irq_o == 1'b0, "R10 collision flag cleared", {wcol_o, irq_o}, 0);

        // R8 overrun
        cpha = 1'b1;
        do_select(); xfer(8'h11, 8, 4, mi); do_deselect();
        chk(ovr_o == 1'b0, "R8 first unread is no overrun", ovr_o, 0);
        do_select(); xfer(8'h22, 8, 4, mi); do_deselect();
        chk(ovr_o == 1'b1 && rd_data_o == 8'h22, "R8 overrun keeps newest",
            {ovr_o, rd_data_o}, {1'b1, 8'h22});
        irq_en = 1'b0; wait_clk(1);
        chk(irq_o == 1'b0, "R10 irq masked", irq_o, 0);
        irq_en = 1'b1;
        ack_all();
        chk(ovr_o == 1'b0 && done_o == 1'b0, "R10 flags cleared", {ovr_o, done_o}, 0);

        // R9 partial character discarded
        cpha = 1'b0;
        do_select(); xfer(8'hFF, 5, 4, mi); do_deselect();
        chk(done_o == 1'b0 && busy_o == 1'b0, "R9 aborted character silent", {done_o, busy_o}, 0);
        pulse_wr(8'hC3);
        do_select(); xfer(8'h5A, 8, 4, mi); do_deselect();
        chk(rd_data_o == 8'h5A && mi == 8'hC3, "R9 next character intact",
            {rd_data_o, mi}, {8'h5A, 8'hC3});
        ack_all();

        // R6 directed resend
        do_select(); xfer(8'h81, 8, 4, mi); do_deselect();
        chk(mi == 8'h5A, "R6 resend without write", mi, 8'h5A);
        ack_all();

        // R1 master mode: engine ignores the bus
        master_en = 1'b1;
        do_select();
        chk(miso_oe_o == 1'b0, "R1 output disabled", miso_oe_o, 0);
        xfer(8'hE7, 8, 4, mi);
        chk(busy_o == 1'b0, "R1 never busy", busy_o, 0);
        do_deselect();
        chk(done_o == 1'b0 && rd_data_o == 8'h81, "R1 no reception",
            {done_o, rd_data_o}, {1'b0, 8'h81});
        master_en = 1'b0;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule